// File: doc/BRIEF.md
# Card Bus Clock and Power Sequencer

This block derives the card bus clock from a faster adapter clock and decides when that clock may run. A three-state power setting (off, up, on) controls whether the card bus drivers may be enabled. The clock either runs at the adapter rate (bypass) or is divided by the programmed value plus two. A clock-enable bit and a power-save rule can both park the clock in its low level. The power-save rule stops the clock once the command and data engines have both been idle for a fixed number of card-clock periods.

The command and data engines receive a one-adapter-cycle strobe at each rising and each falling edge of the card clock. They use these strobes to launch and capture bits without running logic on the card clock itself. A free-running phase counter keeps the period timing even while the output is parked. A restart therefore always lands on a regular rising-edge slot.

Top module: `cclk_pwr_ctrl`

## Requirements
- R1: `pwr_i` encodes the power phase as 2'b00 off, 2'b01 up and 2'b10 on; 2'b11 acts as off. `bus_oe_o` is high only in the cycle after an adapter edge that sampled the on phase.
- R2: `cclk_o` is low during reset. It is also low from the second adapter cycle after the phase leaves on, and it stays low in the off and up phases.
- R3: In divide mode (`bypass_i`=0) the card clock period is `div_i`+2 adapter cycles. The high part lasts floor((`div_i`+2)/2) cycles and the low part lasts the remainder.
- R4: In bypass mode with the clock running, `cclk_o` follows the adapter clock level. Both strobes are high in every adapter cycle.
- R5: A new `div_i` value written while the clock runs does not shorten the current low part. The low part finishes with the old ratio, and the new ratio applies from the next rising edge.
- R6: In divide mode `rise_stb_o` is high for exactly the first adapter cycle in which `cclk_o` is high. `fall_stb_o` is high for exactly the first adapter cycle in which `cclk_o` is low again.
- R7: While `clk_en_i` is low, a card clock that is low stays low. A clock that is high completes its high part and then stays low.
- R8: With `psave_i` high, the clock gives exactly IDLE_N (default 8) more rising edges after both `cmd_idle_i` and `dat_idle_i` go high. It then stays low.
- R9: When either engine leaves idle, the clock restarts on the next rising-edge slot, at most `div_i`+2 adapter cycles later. The idle count restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Adapter clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pwr_i | input | 2 | Power phase select (R1 encoding) |
| clk_en_i | input | 1 | Card clock enable |
| bypass_i | input | 1 | 1: card clock equals adapter clock |
| psave_i | input | 1 | Power-save stop when both engines are idle |
| div_i | input | DIV_W | Divider value, ratio is value plus two |
| cmd_idle_i | input | 1 | Command engine is idle |
| dat_idle_i | input | 1 | Data engine is idle |
| cclk_o | output | 1 | Gated card clock |
| rise_stb_o | output | 1 | Strobe for a card clock rising edge |
| fall_stb_o | output | 1 | Strobe for a card clock falling edge |
| bus_oe_o | output | 1 | Card bus driver enable |

## Verification
The assertions check on every cycle that the driver enable tracks the on phase, and that the clock is parked in the off and up phases. They also check that each strobe marks a true level change of the divided clock, and that neither a low enable nor a full idle count ever produces a rising edge. Some behaviours only the bench's scenarios can show. These are the exact period and high width for each divider value, the old-ratio low part when the divider changes mid-run, the count of eight trailing edges under power save, the prompt restart with a fresh count, and the bypass waveform.

// File: rtl/cclk_pkg.sv
package cclk_pkg;

  typedef enum logic [1:0] {
    PWR_OFF = 2'b00,
    PWR_UP  = 2'b01,
    PWR_ON  = 2'b10,
    PWR_RSV = 2'b11
  } pwr_e;

  // adapter cycles spent high for a divider value
  function automatic int unsigned cclk_hi_len(input int unsigned d);
    return (d + 32'd2) / 32'd2;
  endfunction

  // adapter cycles spent low for a divider value
  function automatic int unsigned cclk_lo_len(input int unsigned d);
    return (d + 32'd2) - cclk_hi_len(d);
  endfunction

endpackage

// File: rtl/cclk_divider.sv
// Free-running phase counter: marks the rising and falling slots of the
// divided clock whether or not the output is allowed to toggle.
module cclk_divider #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             rise_pt_o,
  output logic             fall_pt_o
);
  import cclk_pkg::*;

  localparam int CNT_W = DIV_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic             vlvl_q;
  logic [DIV_W-1:0] div_q;
  int unsigned      len;
  logic             phase_end;

  always_comb begin
    len       = vlvl_q ? cclk_hi_len(32'(div_q)) : cclk_lo_len(32'(div_q));
    phase_end = (32'(cnt_q) == len - 32'd1);
  end

  assign rise_pt_o = phase_end && !vlvl_q;
  assign fall_pt_o = phase_end && vlvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      vlvl_q <= 1'b0;
      div_q  <= '0;
    end else if (phase_end) begin
      cnt_q  <= '0;
      vlvl_q <= ~vlvl_q;
      if (!vlvl_q) div_q <= div_i;   // new ratio only at a rising slot
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/cclk_idle_trk.sv
// Counts card-clock periods while both engines are idle; saturates.
module cclk_idle_trk #(
  parameter int IDLE_N = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cmd_idle_i,
  input  logic dat_idle_i,
  input  logic tick_i,
  output logic full_o
);
  localparam int CW = $clog2(IDLE_N + 1);

  logic [CW-1:0] cnt_q;
  logic          both_idle;

  assign both_idle = cmd_idle_i && dat_idle_i;
  assign full_o    = (cnt_q == CW'(IDLE_N));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!both_idle)        cnt_q <= '0;
    else if (tick_i && !full_o) cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/cclk_gate.sv
// Output level, strobes and bypass path.
module cclk_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic on_i,
  input  logic run_i,
  input  logic bypass_i,
  input  logic rise_pt_i,
  input  logic fall_pt_i,
  output logic lvl_o,
  output logic cclk_o,
  output logic rise_stb_o,
  output logic fall_stb_o
);
  logic lvl_q, byp_run_q, rise_q, fall_q;
  logic do_rise, do_fall;

  assign do_rise = on_i && run_i && !bypass_i && rise_pt_i && !lvl_q;
  assign do_fall = lvl_q && (fall_pt_i || !on_i || bypass_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q     <= 1'b0;
      byp_run_q <= 1'b0;
      rise_q    <= 1'b0;
      fall_q    <= 1'b0;
    end else begin
      if (do_rise)      lvl_q <= 1'b1;
      else if (do_fall) lvl_q <= 1'b0;
      byp_run_q <= on_i && run_i && bypass_i;
      rise_q    <= do_rise;
      fall_q    <= do_fall;
    end
  end

  assign lvl_o      = lvl_q;
  assign cclk_o     = lvl_q | (clk_i & byp_run_q);
  assign rise_stb_o = rise_q | byp_run_q;
  assign fall_stb_o = fall_q | byp_run_q;

endmodule

// File: rtl/cclk_pwr_ctrl.sv
module cclk_pwr_ctrl #(
  parameter int DIV_W  = 8,
  parameter int IDLE_N = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       pwr_i,
  input  logic             clk_en_i,
  input  logic             bypass_i,
  input  logic             psave_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             cmd_idle_i,
  input  logic             dat_idle_i,
  output logic             cclk_o,
  output logic             rise_stb_o,
  output logic             fall_stb_o,
  output logic             bus_oe_o
);
  import cclk_pkg::*;

  pwr_e pwr;
  logic on, run, rise_pt, fall_pt, idle_tick, idle_full, div_lvl, oe_q;

  assign pwr       = pwr_e'(pwr_i);
  assign on        = (pwr == PWR_ON);
  assign idle_tick = bypass_i ? 1'b1 : rise_pt;
  assign run       = clk_en_i && !(psave_i && idle_full);

  cclk_divider #(.DIV_W(DIV_W)) u_div (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .div_i     (div_i),
    .rise_pt_o (rise_pt),
    .fall_pt_o (fall_pt)
  );

  cclk_idle_trk #(.IDLE_N(IDLE_N)) u_idle (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_idle_i (cmd_idle_i),
    .dat_idle_i (dat_idle_i),
    .tick_i     (idle_tick),
    .full_o     (idle_full)
  );

  cclk_gate u_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .on_i       (on),
    .run_i      (run),
    .bypass_i   (bypass_i),
    .rise_pt_i  (rise_pt),
    .fall_pt_i  (fall_pt),
    .lvl_o      (div_lvl),
    .cclk_o     (cclk_o),
    .rise_stb_o (rise_stb_o),
    .fall_stb_o (fall_stb_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) oe_q <= 1'b0;
    else         oe_q <= on;
  end
  assign bus_oe_o = oe_q;

endmodule

// File: rtl/cclk_pwr_ctrl_chk.sv
module cclk_pwr_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] pwr_i,
  input logic       clk_en_i,
  input logic       bypass_i,
  input logic       psave_i,
  input logic       cclk_o,
  input logic       rise_stb_o,
  input logic       fall_stb_o,
  input logic       bus_oe_o,
  input logic       div_lvl,
  input logic       idle_full
);

  a_r1_oe_only_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_i != 2'b10) |=> !bus_oe_o);

  a_r2_park_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_i != 2'b10) |=> !div_lvl);

  a_r6_rise_marks_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bypass_i && $past(!bypass_i) && $past(!bypass_i, 2) && rise_stb_o)
      |-> (cclk_o && !$past(cclk_o)));

  a_r6_fall_marks_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bypass_i && $past(!bypass_i) && $past(!bypass_i, 2) && fall_stb_o)
      |-> (!cclk_o && $past(cclk_o)));

  a_r7_en_low_parks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clk_en_i && !div_lvl) |=> !div_lvl);

  a_r8_psave_parks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psave_i && idle_full && !div_lvl) |=> !div_lvl);

endmodule

bind cclk_pwr_ctrl cclk_pwr_ctrl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pwr_i      (pwr_i),
  .clk_en_i   (clk_en_i),
  .bypass_i   (bypass_i),
  .psave_i    (psave_i),
  .cclk_o     (cclk_o),
  .rise_stb_o (rise_stb_o),
  .fall_stb_o (fall_stb_o),
  .bus_oe_o   (bus_oe_o),
  .div_lvl    (div_lvl),
  .idle_full  (idle_full)
);

// File: tb/tb_cclk_pwr_ctrl.sv
`timescale 1ns/1ps
module tb_cclk_pwr_ctrl;
  localparam int DIV_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] pwr = 2'b00;
  logic clk_en = 1'b1, bypass = 1'b0, psave = 1'b0;
  logic [DIV_W-1:0] div = '0;
  logic cmd_idle = 1'b0, dat_idle = 1'b0;
  logic cclk, rstb, fstb, oe;

  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  cclk_pwr_ctrl #(.DIV_W(DIV_W), .IDLE_N(8)) dut (
    .clk_i(clk), .rst_ni(rst_n), .pwr_i(pwr), .clk_en_i(clk_en),
    .bypass_i(bypass), .psave_i(psave), .div_i(div),
    .cmd_idle_i(cmd_idle), .dat_idle_i(dat_idle),
    .cclk_o(cclk), .rise_stb_o(rstb), .fall_stb_o(fstb), .bus_oe_o(oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wait_rise(output int n);
    n = 0;
    do begin step(); n++; end while (!rstb && n < 2000);
  endtask

  task automatic wait_fall(output int n);
    n = 0;
    do begin step(); n++; end while (!fstb && n < 2000);
  endtask

  task automatic count_rises(input int cyc, output int r, output int hi);
    r = 0; hi = 0;
    for (int i = 0; i < cyc; i++) begin
      step();
      if (rstb) r++;
      if (cclk) hi++;
    end
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n, h, r, hc;
    #1;
    chk(cclk == 1'b0, "R2 reset clock", cclk, 0);
    chk(oe == 1'b0, "R1 reset oe", oe, 0);
    repeat (3) step();
    rst_n = 1'b1;
    // off and up phases, and reserved code
    for (int p = 0; p < 4; p++) begin
      if (p == 2) continue;
      pwr = 2'(p);
      count_rises(40, r, hc);
      chk(r == 0 && hc == 0, "R2 no clock off/up", hc, 0);
      chk(oe == 1'b0, "R1 oe low in non-on phase", oe, 0);
    end
    pwr = 2'b10;
    step();
    chk(oe == 1'b1, "R1 oe in on", oe, 1);

    // divider sweep
    for (int d = 0; d < 18; d++) begin
      int dv;
      dv = (d == 17) ? 255 : d;
      div = DIV_W'(dv);
      repeat (3) wait_rise(n);
      chk(cclk == 1'b1, "R6 clock high at rise strobe", cclk, 1);
      wait_fall(h);
      chk(cclk == 1'b0, "R6 clock low at fall strobe", cclk, 0);
      wait_rise(n);
      chk(h == (dv + 2) / 2, "R3 high width", h, (dv + 2) / 2);
      chk(h + n == dv + 2, "R3 period", h + n, dv + 2);
    end

    // divider change inside a low part
    div = 8'd4;
    repeat (3) wait_rise(n);
    wait_fall(n);
    div = 8'd0;
    wait_rise(n);
    chk(n == 3, "R5 old low part kept", n, 3);
    wait_fall(n);
    chk(n == 1, "R5 new ratio from next rise", n, 1);

    // clock enable low
    div = 8'd2;
    repeat (2) wait_rise(n);
    clk_en = 1'b0;
    repeat (10) step();
    count_rises(40, r, hc);
    chk(r == 0 && hc == 0, "R7 parked low", hc, 0);
    clk_en = 1'b1;
    wait_rise(n);
    chk(n <= 5, "R7 resumes", n, 5);

    // power save
    psave = 1'b1;
    wait_rise(n);
    cmd_idle = 1'b1; dat_idle = 1'b1;
    count_rises(200, r, hc);
    chk(r == 8, "R8 trailing rises", r, 8);
    count_rises(20, r, hc);
    chk(hc == 0, "R8 stays low", hc, 0);
    cmd_idle = 1'b0;
    wait_rise(n);
    chk(n >= 1 && n <= 5, "R9 prompt restart", n, 5);
    cmd_idle = 1'b1;
    count_rises(200, r, hc);
    chk(r == 8, "R9 count restarted", r, 8);
    dat_idle = 1'b0;
    wait_rise(n);
    chk(n <= 5, "R9 restart on data engine", n, 5);
    cmd_idle = 1'b0; psave = 1'b0;

    // bypass
    bypass = 1'b1;
    repeat (3) step();
    chk(cclk == 1'b1, "R4 high after posedge", cclk, 1);
    chk(rstb && fstb, "R4 strobes every cycle", int'(rstb), 1);
    @(negedge clk); #1;
    chk(cclk == 1'b0, "R4 low after negedge", cclk, 0);
    bypass = 1'b0;
    wait_rise(n);
    chk(n <= 6, "R3 divide resumes after bypass", n, 6);

    // power removal mid-run
    wait_rise(n);
    pwr = 2'b01;
    step(); step();
    count_rises(30, r, hc);
    chk(hc == 0, "R2 clock stops when leaving on", hc, 0);
    chk(oe == 1'b0, "R1 oe drops in up", oe, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule